// File: doc/BRIEF.md
# Block transfer and compare sequencer

This block is a sequential engine that performs memory block operations for an 8-bit processor core. A one-cycle start pulse, given while the engine is idle, loads four registers: a 16-bit source pointer, a 16-bit destination pointer, a 16-bit byte count and an 8-bit compare value. It also loads a 3-bit operation code. The engine then runs one pass, or a series of passes, over memory through a one-byte request/acknowledge port. It finishes with a one-cycle done pulse. The pointer, count and flag registers remain visible on the outputs between operations, so a surrounding core can carry on from them.

A copy pass reads a byte at the source pointer and writes it at the destination pointer. It then steps both pointers by one and decrements the count. A compare pass reads a byte at the source pointer and steps only that pointer. It subtracts the byte from the compare value to set flags only, and decrements the count. Idle wait cycles are inserted so that each pass takes a fixed length. In the repeat forms, the point at which the core would rewind its program counter and run the instruction again is shown as a one-cycle `repeat_req` pulse. That pulse is followed by the extra idle cycles that a repeat costs.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a start pulse.
- `ST_READ`: holds a read request until it is acknowledged.
- `ST_WRITE`: holds the write request of a copy pass.
- `ST_PREWAIT`: the idle cycles that come before an incrementing compare.
- `ST_CALC`: the compare subtraction and count update.
- `ST_POSTWAIT`: the idle cycles after a copy write or after a decrementing compare.
- `ST_CHECK`: decides whether to stop or repeat.
- `ST_RPTWAIT`: the idle cycles that a repeat costs.

Transitions:
- `ST_IDLE` goes to `ST_READ` on start.
- `ST_READ` goes on acknowledge to one of three states: `ST_WRITE` for a copy, `ST_PREWAIT` for an incrementing compare, or `ST_CALC` for a decrementing compare.
- `ST_WRITE` goes to `ST_POSTWAIT` on acknowledge.
- `ST_PREWAIT` goes to `ST_CALC` when its wait count runs out.
- `ST_CALC` goes to `ST_POSTWAIT` for a decrementing compare, and otherwise to `ST_CHECK`.
- `ST_POSTWAIT` goes to `ST_CHECK` when its wait count runs out.
- `ST_CHECK` goes to `ST_RPTWAIT` when it repeats, and otherwise to `ST_IDLE`.
- `ST_RPTWAIT` goes to `ST_READ` when its wait count runs out.

Top module: `blkxfer_engine`

## Requirements
- R1: The operation code has three fields: op[2] = 1 selects compare (0 selects copy), op[1] = 1 selects the repeat form, and op[0] = 1 selects decrementing pointers (0 selects incrementing). A start pulse in the idle state loads src_init, dst_init, cnt_init, cmp_init and op, then begins a pass. A start pulse while an operation is running is ignored, along with the values on those inputs at that time.
- R2: A copy pass reads at the source pointer and then writes the byte it read at the destination pointer (mem_we = 1). Both pointers then move by +1 (op[0] = 0) or -1 (op[0] = 1), and the count decreases by 1.
- R3: After a copy pass, flag_n = 0, flag_h = 0 and flag_pv = (count != 0). flag_s and flag_z keep their previous values.
- R4: A compare pass reads once at the source pointer, moves only that pointer, decreases the count by 1 and writes nothing. It computes D = compare value - byte in 8 bits and sets four flags from it: flag_s = D[7], flag_z = (D == 0), flag_h = bit 4 of (value XOR byte XOR D), and flag_n = 1. It sets flag_pv = (count != 0).
- R5: Assume each access is acknowledged in the cycle after its request, and count edges from the edge that samples start. A single copy pass (2 idle cycles after the write) then shows done 6 edges later. A single compare pass (5 idle cycles and one subtraction cycle) shows done 8 edges later.
- R6: An incrementing compare updates its flags after its 5 idle cycles. A decrementing compare updates its flags in the cycle right after the read is acknowledged, and the idle cycles follow. Four edges after start, therefore, only the decrementing form shows its new flag_z.
- R7: A repeated copy keeps making passes while the count is not zero. Each repeat pulses repeat_req for one cycle and costs 1 decision cycle plus 5 idle cycles before the next read.
- R8: A repeated compare keeps making passes only while the count is not zero and flag_z = 0. It stops at the first match or when the count runs out.
- R9: A count of 0 wraps to 0xFFFF on its first decrement. A repeated operation started with a count of 0 therefore covers up to 65536 bytes.
- R10: After reset, all pointers, the count and all flags are 0, and mem_req, repeat_req and done are 0. done is a one-cycle pulse, and the engine issues no request in the cycle after it.
- R11: Only one memory access is outstanding at a time. mem_req, mem_we, mem_addr and mem_wdata stay steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code {compare, repeat, decrement} |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| cnt_init | input | 16 | Byte count loaded at start |
| cmp_init | input | 8 | Compare value loaded at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| byte_cnt | output | 16 | Current byte count |
| flag_s | output | 1 | Sign of compare difference |
| flag_z | output | 1 | Compare match |
| flag_h | output | 1 | Borrow out of bit 3 |
| flag_pv | output | 1 | Count not zero |
| flag_n | output | 1 | Subtract indicator |
| repeat_req | output | 1 | Pulse: the pass is being repeated |
| done | output | 1 | Pulse: the engine is idle again |

## Verification
The handshake assertions assume that mem_ack arrives only while mem_req is high and lasts a single cycle, so that one acknowledge completes exactly one access. The bench's memory model holds to that rule: it raises mem_ack only in the cycle after it sees a request with no acknowledge pending, and drops it on the next edge. The timing requirements depend on that fixed one-cycle latency. Start pulses during a running operation are applied only to check that the engine ignores them.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_PREWAIT,
        ST_CALC,
        ST_POSTWAIT,
        ST_CHECK,
        ST_RPTWAIT
    } state_t;

    typedef struct packed {
        logic is_cmp;
        logic rpt;
        logic dec;
    } opcode_t;

endpackage

// File: rtl/blkxfer_waitctr.sv
module blkxfer_waitctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R5: a loaded wait count runs down by one each cycle
    a_r5_wait_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/blkxfer_ptr_step.sv
module blkxfer_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic         dec,
    output logic [W-1:0] ptr_next
);
    always_comb begin
        if (dec) ptr_next = ptr - 1'b1;
        else     ptr_next = ptr + 1'b1;
    end
endmodule

// File: rtl/blkxfer_cmp_flags.sv
module blkxfer_cmp_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] mem_val,
    output logic         sign,
    output logic         zero,
    output logic         half
);
    logic [W-1:0] diff;

    always_comb begin
        diff = ref_val - mem_val;
        sign = diff[W-1];
        zero = (diff == '0);
        half = (ref_val[4] ^ mem_val[4] ^ diff[4]);
    end
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
    import blkxfer_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 8,
    parameter int COPY_WAIT = 2,
    parameter int CMP_WAIT  = 5,
    parameter int RPT_WAIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic [DATA_W-1:0] cmp_init,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_h,
    output logic              flag_pv,
    output logic              flag_n,
    output logic              repeat_req,
    output logic              done
);
    localparam int MAX_WAIT = (CMP_WAIT > COPY_WAIT)
                            ? ((CMP_WAIT > RPT_WAIT) ? CMP_WAIT : RPT_WAIT)
                            : ((COPY_WAIT > RPT_WAIT) ? COPY_WAIT : RPT_WAIT);
    localparam int WAIT_W = $clog2(MAX_WAIT + 1);
    localparam logic [WAIT_W-1:0] COPY_LD = WAIT_W'(COPY_WAIT - 1);
    localparam logic [WAIT_W-1:0] CMP_LD  = WAIT_W'(CMP_WAIT - 1);
    localparam logic [WAIT_W-1:0] RPT_LD  = WAIT_W'(RPT_WAIT - 1);

    state_t              state_q, state_d;
    opcode_t             op_q;
    logic [ADDR_W-1:0]   src_q, dst_q, src_nx, dst_nx;
    logic [CNT_W-1:0]    cnt_q, cnt_dec;
    logic [DATA_W-1:0]   cmp_q, data_q;
    logic                fs_q, fz_q, fh_q, fpv_q, fn_q;
    logic                cs, cz, ch;
    logic                go_again;
    logic                wait_load, wait_done;
    logic [WAIT_W-1:0]   wait_val;

    blkxfer_ptr_step #(.W(ADDR_W)) u_src_step (
        .ptr(src_q), .dec(op_q.dec), .ptr_next(src_nx));
    blkxfer_ptr_step #(.W(ADDR_W)) u_dst_step (
        .ptr(dst_q), .dec(op_q.dec), .ptr_next(dst_nx));
    blkxfer_cmp_flags #(.W(DATA_W)) u_cmp (
        .ref_val(cmp_q), .mem_val(data_q), .sign(cs), .zero(cz), .half(ch));
    blkxfer_waitctr #(.W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_val),
        .expired(wait_done));

    assign cnt_dec  = cnt_q - 1'b1;
    assign go_again = op_q.rpt && fpv_q && !(op_q.is_cmp && fz_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and wait loading
    always_comb begin
        state_d   = state_q;
        wait_load = 1'b0;
        wait_val  = '0;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_READ;
            ST_READ: begin
                if (mem_ack) begin
                    if (!op_q.is_cmp) begin
                        state_d = ST_WRITE;
                    end else if (op_q.dec) begin
                        state_d = ST_CALC;
                    end else begin
                        state_d   = ST_PREWAIT;
                        wait_load = 1'b1;
                        wait_val  = CMP_LD;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    state_d   = ST_POSTWAIT;
                    wait_load = 1'b1;
                    wait_val  = COPY_LD;
                end
            end
            ST_PREWAIT:  if (wait_done) state_d = ST_CALC;
            ST_CALC: begin
                if (op_q.dec) begin
                    state_d   = ST_POSTWAIT;
                    wait_load = 1'b1;
                    wait_val  = CMP_LD;
                end else begin
                    state_d = ST_CHECK;
                end
            end
            ST_POSTWAIT: if (wait_done) state_d = ST_CHECK;
            ST_CHECK: begin
                if (go_again) begin
                    state_d   = ST_RPTWAIT;
                    wait_load = 1'b1;
                    wait_val  = RPT_LD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RPTWAIT:  if (wait_done) state_d = ST_READ;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            cmp_q  <= '0;
            data_q <= '0;
            fs_q   <= 1'b0;
            fz_q   <= 1'b0;
            fh_q   <= 1'b0;
            fpv_q  <= 1'b0;
            fn_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= opcode_t'(op);
                        src_q <= src_init;
                        dst_q <= dst_init;
                        cnt_q <= cnt_init;
                        cmp_q <= cmp_init;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        src_q  <= src_nx;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        dst_q <= dst_nx;
                        cnt_q <= cnt_dec;
                        fpv_q <= (cnt_dec != '0);
                        fn_q  <= 1'b0;
                        fh_q  <= 1'b0;
                    end
                end
                ST_CALC: begin
                    cnt_q <= cnt_dec;
                    fpv_q <= (cnt_dec != '0);
                    fs_q  <= cs;
                    fz_q  <= cz;
                    fh_q  <= ch;
                    fn_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we     = (state_q == ST_WRITE);
        mem_addr   = (state_q == ST_WRITE) ? dst_q : src_q;
        mem_wdata  = data_q;
        repeat_req = (state_q == ST_CHECK) && go_again;
        done       = (state_q == ST_CHECK) && !go_again;
        src_ptr    = src_q;
        dst_ptr    = dst_q;
        byte_cnt   = cnt_q;
        flag_s     = fs_q;
        flag_z     = fz_q;
        flag_h     = fh_q;
        flag_pv    = fpv_q;
        flag_n     = fn_q;
    end

    // R11: an unacknowledged request is held steady
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R10: after done there is neither a request nor a second done
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!mem_req && !done));

    // R4: a compare operation never writes memory
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q.is_cmp && mem_req) |-> !mem_we);

    // R2: an acknowledged write lowers the count by one
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ack) |=> (byte_cnt == $past(byte_cnt) - 1'b1));

    // R7: a repeat is followed by idle cycles, not an access
    a_r7_rpt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_req |=> !mem_req);

    // R8: a compare never repeats after a match
    a_r8_cmp_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_req && op_q.is_cmp) |-> !flag_z);

    // R3: when the engine stops, pv reflects the count
    a_r3_pv_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_pv == (byte_cnt != '0)));

endmodule

// File: tb/blkxfer_engine_test.sv
module blkxfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [7:0]  cmp_init = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] src_ptr, dst_ptr, byte_cnt;
    logic        flag_s, flag_z, flag_h, flag_pv, flag_n, repeat_req, done;

    int errors = 0;
    int checks = 0;
    int rpt_seen = 0;

    always #2.5 clk = ~clk;

    blkxfer_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .cmp_init(cmp_init), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .byte_cnt(byte_cnt), .flag_s(flag_s), .flag_z(flag_z),
        .flag_h(flag_h), .flag_pv(flag_pv), .flag_n(flag_n),
        .repeat_req(repeat_req), .done(done));

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Memory model: acknowledge one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= pattern(mem_addr);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
    } acc_t;
    acc_t exp_q[$];

    // Monitor: compare each completed access with the scoreboard (R11, R2, R4)
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected access", 32'(mem_addr), 32'hFFFFFFFF);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                chk("R11 access kind", 32'(mem_we), 32'(e.we));
                chk("R11 access addr", 32'(mem_addr), 32'(e.addr));
                if (e.we) chk("R2 write data", 32'(mem_wdata), 32'(e.data));
            end
        end
        if (rst_n && repeat_req) rpt_seen++;
    end

    logic m_s = 0, m_z = 0, m_h = 0, m_n = 0, m_pv = 0;

    task automatic run_op(input logic [2:0] o, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input logic [7:0] v, input bit poke);
        logic [15:0] es = s, ed = d, ec = c;
        logic [8:0]  diff;
        logic [7:0]  b;
        logic        first_z = 0, old_z;
        int passes = 0, n = 0, exp_n;
        logic mid_z = 0;
        bit again;
        old_z = m_z;
        // Model from the requirements
        do begin
            passes++;
            b = pattern(es);
            exp_q.push_back('{1'b0, es, 8'h00});
            if (!o[2]) exp_q.push_back('{1'b1, ed, b});
            es = o[0] ? es - 16'd1 : es + 16'd1;
            if (!o[2]) ed = o[0] ? ed - 16'd1 : ed + 16'd1;
            ec = ec - 16'd1;
            m_pv = (ec != 0);
            if (o[2]) begin
                diff = {1'b0, v} - {1'b0, b};
                m_s = diff[7];
                m_z = (diff[7:0] == 8'h00);
                m_h = v[4] ^ b[4] ^ diff[4];
                m_n = 1'b1;
            end else begin
                m_h = 1'b0;
                m_n = 1'b0;
            end
            if (passes == 1) first_z = m_z;
            again = o[1] && m_pv && !(o[2] && m_z);
        end while (again);
        exp_n = passes * (o[2] ? 8 : 6) + (passes - 1) * 6;
        rpt_seen = 0;

        @(negedge clk);
        op = o; src_init = s; dst_init = d; cnt_init = c; cmp_init = v; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 3) begin
                start = 1'b1; op = ~o; src_init = 16'hDEAD; cnt_init = 16'h0001;
            end else begin
                start = 1'b0;
            end
            if (n == 4) mid_z = flag_z;
            if (done || n > 20000) break;
        end
        chk("R5 R7 done latency", n, exp_n);
        chk("R6 flag_z four edges after start", 32'(mid_z),
            32'((o[2] && o[0]) ? first_z : old_z));
        chk("R2 R4 src_ptr", 32'(src_ptr), 32'(es));
        chk("R2 R1 dst_ptr", 32'(dst_ptr), 32'(ed));
        chk("R9 byte_cnt", 32'(byte_cnt), 32'(ec));
        chk("R3 R4 flag_pv", 32'(flag_pv), 32'(m_pv));
        chk("R3 R4 flag_s", 32'(flag_s), 32'(m_s));
        chk("R3 R4 flag_z", 32'(flag_z), 32'(m_z));
        chk("R3 R4 flag_h", 32'(flag_h), 32'(m_h));
        chk("R3 R4 flag_n", 32'(flag_n), 32'(m_n));
        chk("R7 R8 repeat pulses", rpt_seen, passes - 1);
        chk("R11 all accesses seen", exp_q.size(), 0);
        @(negedge clk);
        chk("R10 done is one pulse", 32'(done), 32'd0);
        chk("R10 no request after done", 32'(mem_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset mem_req", 32'(mem_req), 0);
        chk("R10 reset done", 32'(done), 0);
        chk("R10 reset repeat_req", 32'(repeat_req), 0);
        chk("R10 reset byte_cnt", 32'(byte_cnt), 0);
        chk("R10 reset src_ptr", 32'(src_ptr), 0);
        chk("R10 reset dst_ptr", 32'(dst_ptr), 0);
        chk("R10 reset flags", 32'({flag_s, flag_z, flag_h, flag_pv, flag_n}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3: single copies in both directions
        run_op(3'b000, 16'h0200, 16'h0800, 16'd5, 8'h00, 0);
        run_op(3'b001, 16'h0300, 16'h0900, 16'd1, 8'h00, 0);
        // R7 R1: repeated copy, start poked while busy must be ignored
        run_op(3'b010, 16'h0210, 16'h0A00, 16'd4, 8'h00, 1);
        run_op(3'b011, 16'h0320, 16'h0B20, 16'd3, 8'h00, 0);
        // R4 R6: incrementing compare with match, then decrementing without
        run_op(3'b100, 16'h0400, 16'h1111, 16'd2, pattern(16'h0400), 0);
        run_op(3'b101, 16'h0410, 16'h2222, 16'd7, pattern(16'h0410) + 8'd1, 0);
        // R4: half-borrow case 0x10 - 0x01
        run_op(3'b100, 16'h00A4, 16'h0000, 16'd9, 8'h10, 0);
        // R8: repeated compare stops on match, and on exhaustion
        run_op(3'b110, 16'h0500, 16'h0000, 16'd6, pattern(16'h0502), 1);
        run_op(3'b111, 16'h0600, 16'h0000, 16'd3, 8'h00, 0);
        // R9: count 0 wraps
        run_op(3'b110, 16'h0100, 16'h0000, 16'd0, pattern(16'h0102), 0);
        run_op(3'b100, 16'h0700, 16'h0000, 16'd0, 8'h33, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule